// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by reading two levels of page table out of physical memory. A requester presents the virtual address together with the access kind (read or write, user or privileged) and the root table address. The walker reads one entry from the root table. If that entry is valid, the walker reads one entry from the leaf table that the root entry points to. It then checks the leaf entry and returns either the translated address or a fault code. It handles one walk at a time.

The walker reaches memory through a single read port. A request carries an address and waits for `mem_req_ready`. The matching data word comes back later on `mem_rsp_valid`. A TLB or a core's miss logic normally sits in front of the walker and feeds it misses. Fault handling, page-in and translation caching are outside this block.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held, and on the first cycle after it, `req_ready` is 1, and `mem_req_valid` and `resp_valid` are 0.
- R2: The first read of a walk goes to `ptbr + 4 * vaddr[31:22]`.
- R3: A table entry is 32 bits. Bits [31:12] hold a frame number. Bit 0 is valid, bit 1 allows writes, bit 2 allows user access. If the root entry is valid, the second read goes to `{root_frame, 12'h000} + 4 * vaddr[21:12]`.
- R4: A translation that succeeds returns `resp_paddr = {leaf_frame, vaddr[11:0]}` with `resp_fault` = 0 and `resp_fault_code` = 0.
- R5: If bit 0 of the root entry is clear, the walk returns code 1 with `resp_fault` = 1 and `resp_paddr` = 0. No second read is issued.
- R6: If bit 0 of the leaf entry is clear, the walk returns code 2 with `resp_paddr` = 0. This code wins over any rights violation.
- R7: A write to a valid leaf entry whose bit 1 is clear returns code 3 (protection). A read of the same entry succeeds.
- R8: A user access to a valid leaf entry whose bit 2 is clear returns code 3. The rights bits of the root entry are never checked.
- R9: `req_ready` is 0 from the cycle after a request is accepted until the response. `resp_valid` lasts one cycle, and `req_ready` is 1 on the cycle after it.
- R10: Once `mem_req_valid` is raised, it stays high with an unchanged `mem_req_addr` until a cycle in which `mem_req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| ptbr | input | 32 | Root table physical address, sampled on accept |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry word |
| resp_valid | output | 1 | Walk result strobe |
| resp_paddr | output | 32 | Physical address, 0 on fault |
| resp_fault | output | 1 | Walk ended in a fault |
| resp_fault_code | output | 2 | 0 none, 1 root invalid, 2 leaf invalid, 3 protection |

## Verification
The assertions assume that memory returns exactly one data word per accepted read. They also assume that no data word arrives while the walker has no read outstanding. The bench memory is built to keep both rules: it holds at most one pending read and replies after a delay of 0 to 2 cycles. Its ready line stalls on a fixed pattern, so request holding is exercised. The tables are computed from the address, not stored. This lets the sweep cover root indices across the full range, leaf indices with every rights pattern, and all four access kinds. It also covers a root table region that holds no valid entry.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [1:0] {
      FLT_NONE       = 2'd0,
      FLT_L1_INVALID = 2'd1,
      FLT_L2_INVALID = 2'd2,
      FLT_PROT       = 2'd3
   } ptw_fault_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_FETCH1,
      S_WAIT1,
      S_FETCH2,
      S_WAIT2,
      S_DONE
   } ptw_state_e;

   localparam int FLAG_VALID = 0;
   localparam int FLAG_WRITE = 1;
   localparam int FLAG_USER  = 2;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int PA_W    = 32,
   parameter int OFF_W   = 12,
   parameter int IDX1_W  = 10,
   parameter int IDX2_W  = 10,
   parameter int ENTRY_W = 32
) (
   input  logic                    second_level,
   input  logic [PA_W-1:0]         root_base,
   input  logic [PA_W-OFF_W-1:0]   table_frame,
   input  logic [IDX1_W-1:0]       idx1,
   input  logic [IDX2_W-1:0]       idx2,
   output logic [PA_W-1:0]         entry_addr
);
   localparam int ENT_SH = $clog2(ENTRY_W / 8);

   logic [PA_W-1:0] tbl_base;
   logic [PA_W-1:0] scaled;

   always_comb begin
      if (second_level) begin
         tbl_base = {table_frame, {OFF_W{1'b0}}};
         scaled   = PA_W'(idx2) << ENT_SH;
      end else begin
         tbl_base = root_base;
         scaled   = PA_W'(idx1) << ENT_SH;
      end
      entry_addr = tbl_base + scaled;
   end

endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check #(
   parameter bit ENFORCE = 1'b1
) (
   input  logic may_write,
   input  logic may_user,
   input  logic is_write,
   input  logic is_user,
   output logic allowed
);
   generate
      if (ENFORCE) begin : g_enforce
         assign allowed = (!is_write || may_write) && (!is_user || may_user);
      end else begin : g_bypass
         logic unused_rights;
         assign unused_rights = ^{may_write, may_user, is_write, is_user};
         assign allowed = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int VA_W           = 32,
   parameter int PA_W           = 32,
   parameter int OFF_W          = 12,
   parameter int IDX1_W         = 10,
   parameter int IDX2_W         = 10,
   parameter int ENTRY_W        = 32,
   parameter bit ENFORCE_RIGHTS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VA_W-1:0]    req_vaddr,
   input  logic               req_write,
   input  logic               req_user,
   input  logic [PA_W-1:0]    ptbr,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [PA_W-1:0]    mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [ENTRY_W-1:0] mem_rsp_data,
   output logic               resp_valid,
   output logic [PA_W-1:0]    resp_paddr,
   output logic               resp_fault,
   output logic [1:0]         resp_fault_code
);
   localparam int FRAME_W  = PA_W - OFF_W;
   localparam int FLAGS_W  = 3;
   localparam int SPARE_W  = ENTRY_W - FRAME_W - FLAGS_W;

   generate
      if (IDX1_W + IDX2_W + OFF_W != VA_W) begin : g_bad_split
         $error("ptw_walker: index and offset widths must add up to VA_W");
      end
      if (ENTRY_W % 8 != 0 || (ENTRY_W & (ENTRY_W - 1)) != 0) begin : g_bad_entry
         $error("ptw_walker: ENTRY_W must be a power of two number of bytes");
      end
      if (SPARE_W < 0) begin : g_bad_fit
         $error("ptw_walker: entry too narrow for frame plus flags");
      end
   endgenerate

   ptw_state_e            state_q;
   logic [VA_W-1:0]       va_q;
   logic                  wr_q;
   logic                  usr_q;
   logic [PA_W-1:0]       base_q;
   logic [FRAME_W-1:0]    tbl_frame_q;
   logic [PA_W-1:0]       paddr_q;
   ptw_fault_e            code_q;

   logic [IDX1_W-1:0]     idx1;
   logic [IDX2_W-1:0]     idx2;
   logic [OFF_W-1:0]      page_off;
   logic [FRAME_W-1:0]    rsp_frame;
   logic                  rsp_ok;
   logic                  rights_ok;

   assign idx1      = va_q[VA_W-1 -: IDX1_W];
   assign idx2      = va_q[OFF_W +: IDX2_W];
   assign page_off  = va_q[OFF_W-1:0];
   assign rsp_frame = mem_rsp_data[ENTRY_W-1 -: FRAME_W];
   assign rsp_ok    = mem_rsp_data[FLAG_VALID];

   generate
      if (SPARE_W > 0) begin : g_spare
         logic [SPARE_W-1:0] unused_spare;
         assign unused_spare = mem_rsp_data[FLAGS_W +: SPARE_W];
      end
   endgenerate

   ptw_addr_gen #(
      .PA_W    (PA_W),
      .OFF_W   (OFF_W),
      .IDX1_W  (IDX1_W),
      .IDX2_W  (IDX2_W),
      .ENTRY_W (ENTRY_W)
   ) u_addr (
      .second_level (state_q == S_FETCH2),
      .root_base    (base_q),
      .table_frame  (tbl_frame_q),
      .idx1         (idx1),
      .idx2         (idx2),
      .entry_addr   (mem_req_addr)
   );

   ptw_perm_check #(
      .ENFORCE (ENFORCE_RIGHTS)
   ) u_perm (
      .may_write (mem_rsp_data[FLAG_WRITE]),
      .may_user  (mem_rsp_data[FLAG_USER]),
      .is_write  (wr_q),
      .is_user   (usr_q),
      .allowed   (rights_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         va_q        <= '0;
         wr_q        <= 1'b0;
         usr_q       <= 1'b0;
         base_q      <= '0;
         tbl_frame_q <= '0;
         paddr_q     <= '0;
         code_q      <= FLT_NONE;
      end else begin
         unique case (state_q)
            S_IDLE: begin
               if (req_valid) begin
                  va_q    <= req_vaddr;
                  wr_q    <= req_write;
                  usr_q   <= req_user;
                  base_q  <= ptbr;
                  state_q <= S_FETCH1;
               end
            end
            S_FETCH1: if (mem_req_ready) state_q <= S_WAIT1;
            S_WAIT1: begin
               if (mem_rsp_valid) begin
                  if (!rsp_ok) begin
                     code_q  <= FLT_L1_INVALID;
                     paddr_q <= '0;
                     state_q <= S_DONE;
                  end else begin
                     tbl_frame_q <= rsp_frame;
                     state_q     <= S_FETCH2;
                  end
               end
            end
            S_FETCH2: if (mem_req_ready) state_q <= S_WAIT2;
            S_WAIT2: begin
               if (mem_rsp_valid) begin
                  if (!rsp_ok) begin
                     code_q  <= FLT_L2_INVALID;
                     paddr_q <= '0;
                  end else if (!rights_ok) begin
                     code_q  <= FLT_PROT;
                     paddr_q <= '0;
                  end else begin
                     code_q  <= FLT_NONE;
                     paddr_q <= {rsp_frame, page_off};
                  end
                  state_q <= S_DONE;
               end
            end
            S_DONE:  state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign req_ready       = (state_q == S_IDLE);
   assign mem_req_valid   = (state_q == S_FETCH1) || (state_q == S_FETCH2);
   assign resp_valid      = (state_q == S_DONE);
   assign resp_paddr      = paddr_q;
   assign resp_fault_code = code_q;
   assign resp_fault      = (code_q != FLT_NONE);

   // R10
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   // R9
   resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid && req_ready);

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req_valid && !resp_valid);

   // R4
   off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && !resp_fault |-> resp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]);

   // R5
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && resp_fault |-> resp_paddr == '0);

   // R3
   rsp_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |-> (state_q == S_WAIT1) || (state_q == S_WAIT2));

endmodule

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;

   localparam logic [31:0] BASE_A = 32'h0001_0000;
   localparam logic [31:0] BASE_B = 32'h0003_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic [31:0] ptbr = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        resp_valid;
   logic [31:0] resp_paddr;
   logic        resp_fault;
   logic [1:0]  resp_fault_code;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int req_total = 0;
   int hold_viol = 0;
   int stalls = 0;
   logic [31:0] addr_log [0:3];
   logic        pend = 1'b0;
   logic [31:0] pend_addr = '0;
   int          dly = 0;
   logic        prev_stall = 1'b0;
   logic [31:0] prev_addr = '0;

   always #4 clk = ~clk;

   ptw_walker uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_write(req_write), .req_user(req_user), .ptbr(ptbr),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .resp_valid(resp_valid),
      .resp_paddr(resp_paddr), .resp_fault(resp_fault),
      .resp_fault_code(resp_fault_code)
   );

   function automatic logic [19:0] leaf_frame(int i, int j);
      return (20'(i) << 10 | 20'(j)) ^ 20'h5A5A5;
   endfunction

   function automatic bit leaf_valid(int i, int j);
      return ((i + j) % 5) != 4;
   endfunction

   function automatic bit root_valid(int i);
      return (i % 7) != 3;
   endfunction

   function automatic logic [31:0] mem_word(logic [31:0] a);
      int i, j;
      if (a >= BASE_A && a < BASE_A + 32'd4096) begin
         i = int'((a - BASE_A) >> 2);
         if (!root_valid(i)) return 32'h0000_0FFE;
         return {20'h00100 + 20'(i), 12'h001};
      end
      if (a[31:12] >= 20'h00100 && a[31:12] < 20'h00500) begin
         i = int'(a[31:12] - 20'h00100);
         j = int'(a[11:2]);
         return {leaf_frame(i, j), 9'h0, ~a[3], ~a[2], leaf_valid(i, j)};
      end
      return 32'hDEAD_BEE0;
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      mem_req_ready <= (cyc % 5) != 2;
      mem_rsp_valid <= 1'b0;
      if (!rst_n) begin
         pend <= 1'b0;
      end else begin
         if (pend) begin
            if (dly == 0) begin
               mem_rsp_valid <= 1'b1;
               mem_rsp_data  <= mem_word(pend_addr);
               pend          <= 1'b0;
            end else begin
               dly <= dly - 1;
            end
         end
         if (mem_req_valid && mem_req_ready) begin
            pend      <= 1'b1;
            pend_addr <= mem_req_addr;
            dly       <= cyc % 3;
            addr_log[req_total[1:0]] <= mem_req_addr;
            req_total <= req_total + 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stall && !(mem_req_valid && mem_req_addr == prev_addr))
            hold_viol = hold_viol + 1;
         prev_stall = mem_req_valid && !mem_req_ready;
         prev_addr  = mem_req_addr;
         if (prev_stall) stalls = stalls + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #1200000;
      errors = errors + 1;
      $display("FAIL R9 watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      finish_run();
   end

   task automatic walk(input int i, input int j, input logic [11:0] off,
                       input bit wr, input bit us, input logic [31:0] base);
      int start, n, t;
      bit busy_ok;
      logic [31:0] va, pa_e, a2_e;
      logic [1:0] code_e;
      string tag;
      va = {10'(i), 10'(j), off};
      if (base != BASE_A || !root_valid(i)) begin
         code_e = 2'd1; pa_e = '0; tag = "R5";
      end else if (!leaf_valid(i, j)) begin
         code_e = 2'd2; pa_e = '0; tag = "R6";
      end else if (wr && j[0]) begin
         code_e = 2'd3; pa_e = '0; tag = "R7";
      end else if (us && j[1]) begin
         code_e = 2'd3; pa_e = '0; tag = "R8";
      end else begin
         code_e = 2'd0; pa_e = {leaf_frame(i, j), off};
         tag = (wr || us) ? "R8" : "R4";
      end
      a2_e = ({20'h00100 + 20'(i), 12'h000}) + 32'(j * 4);

      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_vaddr = va; req_write = wr; req_user = us; ptbr = base;
      req_valid = 1'b1;
      start = req_total;
      @(negedge clk);
      req_valid = 1'b0;
      busy_ok = 1'b1;
      t = 0;
      while (!resp_valid && t < 100) begin
         if (req_ready) busy_ok = 1'b0;
         @(negedge clk);
         t++;
      end
      n = req_total - start;
      chk(busy_ok && t < 100, "R9", {31'b0, busy_ok}, 32'h1);
      chk(resp_fault_code == code_e && resp_fault == (code_e != 0), tag,
          {29'b0, resp_fault, resp_fault_code}, {29'b0, code_e != 0, code_e});
      chk(resp_paddr == pa_e, tag, resp_paddr, pa_e);
      chk(addr_log[start[1:0]] == base + 32'(i * 4), "R2",
          addr_log[start[1:0]], base + 32'(i * 4));
      if (code_e == 2'd1) begin
         chk(n == 1, "R5", 32'(n), 32'd1);
      end else begin
         chk(n == 2, "R3", 32'(n), 32'd2);
         chk(addr_log[2'(start + 1)] == a2_e, "R3", addr_log[2'(start + 1)], a2_e);
      end
      @(negedge clk);
      chk(req_ready && !resp_valid, "R9", {30'b0, req_ready, resp_valid}, 32'h2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready && !mem_req_valid && !resp_valid, "R1",
          {29'b0, req_ready, mem_req_valid, resp_valid}, 32'h4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !mem_req_valid && !resp_valid, "R1",
          {29'b0, req_ready, mem_req_valid, resp_valid}, 32'h4);

      for (int i = 0; i < 1024; i += 31) begin
         for (int j = 0; j < 1040; j += 97) begin
            for (int k = 0; k < 4; k++) begin
               walk(i, (j > 1023) ? 1023 : j, 12'((i * 13 + j * 7 + k) & 12'hFFF),
                    k[0], k[1], BASE_A);
            end
         end
      end
      walk(1023, 1023, 12'hFFF, 1'b0, 1'b0, BASE_A);
      walk(1, 0, 12'h000, 1'b0, 1'b0, BASE_A);
      for (int i = 0; i < 1024; i += 127) begin
         walk(i, 5, 12'h123, 1'b1, 1'b1, BASE_B);
      end

      chk(hold_viol == 0, "R10", 32'(hold_viol), 32'd0);
      chk(stalls > 0, "R10", 32'(stalls), 32'd1);
      finish_run();
   end

endmodule